// File: doc/BRIEF.md
# Descriptor Ring Queue Engine

This block drives one endpoint's transfers from a chain of 16-byte descriptors kept in a small local descriptor memory. Software writes descriptors through a word-wide memory port and hands each one to the engine by setting its ownership bit. It loads a start address and issues start, stop and resume commands. The engine fetches the descriptor at its current pointer and checks ownership, bypass and length. It hands the buffer address and length to a data mover over a request/acknowledge pair, writes back the actual length and clears ownership. It then follows the next-descriptor pointer.

A descriptor slot is four little-endian 32-bit words. Word 0 holds the flag byte in bits 7:0, the extension flag byte in bits 15:8 and the requested length in bits 31:16. Word 1 is the low 32 bits of the next-descriptor address. Word 2 is the low 32 bits of the buffer address. Word 3 holds the extension-address halfword in bits 15:0 and receives the actual length in bits 31:16. Flag bit 0 is hardware ownership, bit 2 is bypass and bit 7 requests a completion pulse. Extension flag bit 5 asks the mover for a trailing zero-length packet. Addresses are 36 bits wide. Extension-address bits 3:0 supply buffer address bits 35:32, and bits 7:4 supply next-pointer bits 35:32.

When the engine reaches a descriptor it does not own, it waits there until software resumes it. A zero-length transmit descriptor is never handed to the mover. The engine flags a length error and halts on it, so software can send the packet by another path, mark the descriptor as bypass and resume.

Top module: `dring_queue_engine`

## Requirements
- R1: After reset the engine is inactive, with `active`, `len_err`, `done` and `dm_req` low. While inactive it never raises `dm_req` or `done`.
- R2: A start command while inactive loads `cur_ptr` from the start-address register and raises `active` in the next cycle. A start command while active has no effect on `cur_ptr`.
- R3: If the descriptor at `cur_ptr` has ownership bit 0 clear, the engine stays active, issues no mover request and keeps `cur_ptr` on it. A resume command re-reads that descriptor and proceeds only if its ownership bit is now set.
- R4: For an owned, non-bypass descriptor with non-zero length, the engine holds `dm_req` until `dm_ack` arrives. During the request it presents `dm_addr` = {word3[3:0], word2}, `dm_len` = word0[31:16] and `dm_zlp` = word0[13].
- R5: On retiring a descriptor the engine writes the actual length into word3[31:16] and clears word0 bit 0. It raises `done` for exactly one cycle only when flag bit 7 is set, then moves `cur_ptr` to {word3[7:4], word1}.
- R6: An owned descriptor with bypass bit 2 set is retired without a mover request, with an actual length of 0.
- R7: In transmit mode, an owned non-bypass descriptor whose length is 0 makes the engine raise `len_err` and halt with `cur_ptr` unchanged and no request. A resume or start clears `len_err`.
- R8: A stop command while no mover request is open drops `active` in the next cycle. A stop during an open request lets that transfer finish and write back if `dm_ack` comes. In every case `active` falls within STOP_LIMIT cycles.
- R9: Resume and stop commands while inactive have no effect. When commands coincide, stop takes priority over start and start over resume.
- R10: The descriptor slot is selected by `cur_ptr` bits [IDX_W+3:4] alone. The upper address bits, including the nibble taken from the extension halfword, do not affect which slot is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_we | input | 1 | Descriptor memory word write enable |
| sw_addr | input | MEM_AW | Descriptor memory word address (slot*4 + word) |
| sw_wdata | input | 32 | Descriptor memory write data |
| sw_rdata | output | 32 | Descriptor memory read data at `sw_addr` |
| sa_we | input | 1 | Start-address register write enable |
| sa_wdata | input | 36 | Start-address register write data |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_resume | input | 1 | Resume command pulse |
| active | output | 1 | Queue active flag |
| cur_ptr | output | 36 | Current descriptor address |
| len_err | output | 1 | Zero-length error flag |
| done | output | 1 | One-cycle completion pulse |
| dm_req | output | 1 | Data mover request |
| dm_addr | output | 36 | Buffer address for the mover |
| dm_len | output | 16 | Requested length |
| dm_zlp | output | 1 | Trailing zero-length packet request |
| dm_ack | input | 1 | Data mover acknowledge |
| dm_actual | input | 16 | Length actually moved, valid with `dm_ack` |

## Verification
The hardest state to reach is a stop that arrives while a mover request is open. The bench has to leave the request unanswered long enough to see the engine hold it, and then either starve it until the STOP_LIMIT abort or acknowledge it late so the writeback still lands. The bench's mover model has an enable and an acknowledge delay for this purpose. It starts the queue on an owned descriptor, waits until `dm_req` is seen, and only then pulses stop. The zero-length halt followed by a bypass resume is reached by editing the halted descriptor through the memory port before resuming.

// File: rtl/dring_queue_engine.sv
module dring_queue_engine #(
  parameter int NUM_DESC   = 8,
  parameter int STOP_LIMIT = 1000,
  parameter bit IS_TX      = 1'b1,
  localparam int IDX_W     = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int MEM_AW    = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [MEM_AW-1:0] sw_addr,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  input  logic              sa_we,
  input  logic [35:0]       sa_wdata,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_resume,
  output logic              active,
  output logic [35:0]       cur_ptr,
  output logic              len_err,
  output logic              done,
  output logic              dm_req,
  output logic [35:0]       dm_addr,
  output logic [15:0]       dm_len,
  output logic              dm_zlp,
  input  logic              dm_ack,
  input  logic [15:0]       dm_actual
);

  localparam int WORDS = 4 * NUM_DESC;
  localparam int CNT_W = $clog2(STOP_LIMIT);

  typedef enum logic [2:0] {ST_OFF, ST_CHECK, ST_MOVE, ST_WB, ST_PARK, ST_HALT} st_t;

  logic [31:0]       mem [WORDS];
  st_t               st;
  logic [35:0]       ptr, sa_q;
  logic [15:0]       act_q;
  logic              ioc_q, stop_pend, err_q, zlen;
  logic [CNT_W-1:0]  stop_cnt;
  logic [IDX_W-1:0]  slot;
  logic [MEM_AW-1:0] a0, a1, a2, a3;

  assign slot = ptr[IDX_W+3:4];
  assign a0 = {slot, 2'd0};
  assign a1 = {slot, 2'd1};
  assign a2 = {slot, 2'd2};
  assign a3 = {slot, 2'd3};

  generate
    if (IS_TX) begin : g_tx
      assign zlen = (mem[a0][31:16] == 16'd0);
    end else begin : g_rx
      assign zlen = 1'b0;
    end
  endgenerate

  assign sw_rdata = mem[sw_addr];
  assign active   = (st != ST_OFF);
  assign cur_ptr  = ptr;
  assign len_err  = err_q;
  assign done     = (st == ST_WB) && ioc_q;
  assign dm_req   = (st == ST_MOVE);
  assign dm_addr  = {mem[a3][3:0], mem[a2]};
  assign dm_len   = mem[a0][31:16];
  assign dm_zlp   = mem[a0][13];

  always_ff @(posedge clk) begin
    if (sw_we) mem[sw_addr] <= sw_wdata;
    if (st == ST_WB) begin
      mem[a0] <= {mem[a0][31:1], 1'b0};
      mem[a3] <= {act_q, mem[a3][15:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sa_q <= '0;
    else if (sa_we) sa_q <= sa_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_OFF;
      ptr       <= '0;
      act_q     <= '0;
      ioc_q     <= 1'b0;
      stop_pend <= 1'b0;
      stop_cnt  <= '0;
      err_q     <= 1'b0;
    end else begin
      case (st)
        ST_OFF: begin
          if (cmd_start && !cmd_stop) begin
            ptr   <= sa_q;
            err_q <= 1'b0;
            st    <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (cmd_stop) st <= ST_OFF;
          else if (!mem[a0][0]) st <= ST_PARK;
          else if (mem[a0][2]) begin
            act_q <= '0;
            ioc_q <= mem[a0][7];
            st    <= ST_WB;
          end else if (zlen) begin
            err_q <= 1'b1;
            st    <= ST_HALT;
          end else begin
            ioc_q <= mem[a0][7];
            st    <= ST_MOVE;
          end
        end
        ST_PARK, ST_HALT: begin
          if (cmd_stop) st <= ST_OFF;
          else if (cmd_resume) begin
            err_q <= 1'b0;
            st    <= ST_CHECK;
          end
        end
        ST_MOVE: begin
          if (cmd_stop && !stop_pend) begin
            stop_pend <= 1'b1;
            stop_cnt  <= '0;
          end
          if (dm_ack) begin
            act_q <= dm_actual;
            st    <= ST_WB;
          end else if (stop_pend) begin
            if (stop_cnt == CNT_W'(STOP_LIMIT - 3)) begin
              stop_pend <= 1'b0;
              st        <= ST_OFF;
            end else begin
              stop_cnt <= stop_cnt + 1'b1;
            end
          end
        end
        ST_WB: begin
          ptr <= {mem[a3][7:4], mem[a1]};
          if (stop_pend || cmd_stop) begin
            stop_pend <= 1'b0;
            st        <= ST_OFF;
          end else begin
            st <= ST_CHECK;
          end
        end
        default: st <= ST_OFF;
      endcase
    end
  end

endmodule

// File: rtl/dring_queue_engine_chk.sv
module dring_queue_engine_chk #(
  parameter int STOP_LIMIT = 1000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_start,
  input logic        cmd_stop,
  input logic        cmd_resume,
  input logic        active,
  input logic [35:0] cur_ptr,
  input logic        len_err,
  input logic        done,
  input logic        dm_req,
  input logic        dm_ack,
  input logic [35:0] sa_q
);

  int unsigned stop_cycles;
  logic        stopping;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopping    <= 1'b0;
      stop_cycles <= 0;
    end else if (!active) begin
      stopping    <= 1'b0;
      stop_cycles <= 0;
    end else if (cmd_stop || stopping) begin
      stopping    <= 1'b1;
      stop_cycles <= stop_cycles + 1;
    end
  end

  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!dm_req && !done)); // R1

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && cmd_start && !cmd_stop) |=> (active && cur_ptr == $past(sa_q))); // R2

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_req && !dm_ack) |=> (dm_req || !active)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_ERR_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (len_err && !cmd_start && !cmd_resume) |=> $stable(cur_ptr)); // R7

  AST_STOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (stop_cycles < STOP_LIMIT)); // R8

  AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cmd_start) |=> !active); // R9

endmodule

bind dring_queue_engine dring_queue_engine_chk #(.STOP_LIMIT(STOP_LIMIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
  .cmd_resume(cmd_resume), .active(active), .cur_ptr(cur_ptr), .len_err(len_err),
  .done(done), .dm_req(dm_req), .dm_ack(dm_ack), .sa_q(sa_q)
);

// File: tb/dring_queue_engine_tb_top.sv
module dring_queue_engine_tb_top;
  localparam int STOP_LIMIT = 1000;
  localparam int MEM_AW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_we = 1'b0; logic [MEM_AW-1:0] sw_addr = '0; logic [31:0] sw_wdata = '0; logic [31:0] sw_rdata;
  logic sa_we = 1'b0; logic [35:0] sa_wdata = '0;
  logic cmd_start = 1'b0, cmd_stop = 1'b0, cmd_resume = 1'b0;
  logic active, len_err, done, dm_req, dm_zlp;
  logic [35:0] cur_ptr, dm_addr; logic [15:0] dm_len;
  logic dm_ack = 1'b0; logic [15:0] dm_actual = '0;

  int checks = 0, fails = 0, done_cnt = 0, req_cnt = 0;
  bit ack_en = 1'b1; int ack_delay = 0, wait_cnt = 0;
  logic [35:0] addr_log [8]; logic zlp_log [8];

  always #10 clk = ~clk;

  dring_queue_engine #(.NUM_DESC(8), .STOP_LIMIT(STOP_LIMIT), .IS_TX(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .sa_we(sa_we), .sa_wdata(sa_wdata), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_resume(cmd_resume), .active(active), .cur_ptr(cur_ptr),
    .len_err(len_err), .done(done), .dm_req(dm_req), .dm_addr(dm_addr), .dm_len(dm_len),
    .dm_zlp(dm_zlp), .dm_ack(dm_ack), .dm_actual(dm_actual));

  initial begin
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
      if (dm_ack) dm_ack = 1'b0;
      else if (dm_req && ack_en) begin
        if (wait_cnt >= ack_delay) begin
          if (req_cnt < 8) begin addr_log[req_cnt] = dm_addr; zlp_log[req_cnt] = dm_zlp; end
          dm_actual = dm_len - 16'd1;
          dm_ack = 1'b1;
          req_cnt++;
          wait_cnt = 0;
        end else wait_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input int a, input logic [31:0] d);
    @(negedge clk); sw_addr = MEM_AW'(a); sw_wdata = d; sw_we = 1'b1;
    @(negedge clk); sw_we = 1'b0;
  endtask

  task automatic rd_word(input int a, output logic [31:0] d);
    @(negedge clk); sw_addr = MEM_AW'(a); #1 d = sw_rdata;
  endtask

  task automatic put_desc(input int i, input logic [7:0] flg, input logic [7:0] xf, input logic [15:0] len,
                          input logic [31:0] buff, input logic [3:0] bnib, input int nxt, input logic [3:0] nnib);
    wr_word(i*4+0, {len, xf, flg});
    wr_word(i*4+1, 32'(nxt*16));
    wr_word(i*4+2, buff);
    wr_word(i*4+3, {16'h0, 8'h0, nnib, bnib});
  endtask

  task automatic set_sa(input logic [35:0] v);
    @(negedge clk); sa_wdata = v; sa_we = 1'b1; @(negedge clk); sa_we = 1'b0;
  endtask

  task automatic pulse_start;  @(negedge clk); cmd_start = 1'b1;  @(negedge clk); cmd_start = 1'b0;  endtask
  task automatic pulse_stop;   @(negedge clk); cmd_stop = 1'b1;   @(negedge clk); cmd_stop = 1'b0;   endtask
  task automatic pulse_resume; @(negedge clk); cmd_resume = 1'b1; @(negedge clk); cmd_resume = 1'b0; endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic t_reset;
    idle(1);
    check(!active && !len_err && !done && !dm_req, "R1 reset outputs quiet",
          {active, len_err, done, dm_req}, 0);
  endtask

  task automatic t_chain;
    logic [31:0] w;
    put_desc(0, 8'h81, 8'h00, 16'd40,  32'h1000_0000, 4'hA, 1, 4'h0);
    put_desc(1, 8'h01, 8'h20, 16'd8,   32'h0000_2000, 4'h0, 2, 4'h0);
    put_desc(2, 8'h81, 8'h00, 16'd100, 32'h0000_3000, 4'h0, 3, 4'h3);
    put_desc(3, 8'h00, 8'h00, 16'd12,  32'h0000_4000, 4'h0, 4, 4'h0);
    set_sa(36'h0);
    pulse_start;
    idle(30);
    check(req_cnt == 3, "R4 three mover requests", req_cnt, 3);
    check(addr_log[0] == 36'hA_1000_0000, "R4 buffer address with nibble", addr_log[0], 36'hA_1000_0000);
    check(zlp_log[1] == 1'b1 && zlp_log[0] == 1'b0, "R4 trailing zlp flag", {zlp_log[1], zlp_log[0]}, 2'b10);
    check(done_cnt == 2, "R5 done only with completion bit", done_cnt, 2);
    check(cur_ptr == 36'h3_0000_0030, "R5 R3 pointer parks on unowned", cur_ptr, 36'h3_0000_0030);
    check(active && !dm_req, "R3 parked active without request", {active, dm_req}, 2'b10);
    rd_word(0, w);  check(w[0] == 1'b0, "R5 ownership cleared", w[0], 0);
    rd_word(3, w);  check(w[31:16] == 16'd39, "R5 actual length written back", w[31:16], 39);
    rd_word(11, w); check(w[31:16] == 16'd99, "R5 actual length desc2", w[31:16], 99);
  endtask

  task automatic t_start_ignored;
    set_sa(36'h50);
    pulse_start;
    idle(4);
    check(cur_ptr == 36'h3_0000_0030, "R2 start while active ignored", cur_ptr, 36'h3_0000_0030);
  endtask

  task automatic t_resume_unowned;
    pulse_resume;
    idle(6);
    check(cur_ptr == 36'h3_0000_0030 && req_cnt == 3, "R3 resume on unowned stays",
          cur_ptr, 36'h3_0000_0030);
  endtask

  task automatic t_bypass;
    logic [31:0] w;
    wr_word(12, {16'd12, 8'h00, 8'h85});
    pulse_resume;
    idle(8);
    check(req_cnt == 3, "R6 bypass issues no request", req_cnt, 3);
    check(done_cnt == 3, "R6 bypass completion pulse", done_cnt, 3);
    check(cur_ptr == 36'h40, "R10 slot chosen by low bits, then advance", cur_ptr, 36'h40);
    rd_word(12, w); check(w[0] == 1'b0, "R6 bypass ownership cleared", w[0], 0);
    rd_word(15, w); check(w[31:16] == 16'd0, "R6 bypass actual zero", w[31:16], 0);
  endtask

  task automatic t_zero_len;
    put_desc(4, 8'h81, 8'h00, 16'd0, 32'h0000_5000, 4'h0, 5, 4'h0);
    put_desc(5, 8'h00, 8'h00, 16'd16, 32'h0000_6000, 4'h0, 6, 4'h0);
    pulse_resume;
    idle(8);
    check(len_err && active, "R7 zero length raises error", {len_err, active}, 2'b11);
    check(cur_ptr == 36'h40 && req_cnt == 3, "R7 halted on descriptor", cur_ptr, 36'h40);
    wr_word(16, {16'd0, 8'h00, 8'h85});
    pulse_resume;
    idle(8);
    check(!len_err, "R7 resume clears error", len_err, 0);
    check(done_cnt == 4 && cur_ptr == 36'h50, "R7 bypassed after error", cur_ptr, 36'h50);
  endtask

  task automatic t_stop_idle;
    @(negedge clk); cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
    check(!active, "R8 stop while parked drops active next cycle", active, 0);
    pulse_resume;
    idle(4);
    check(!active && cur_ptr == 36'h50, "R9 resume while inactive ignored", {active, cur_ptr}, 36'h50);
    @(negedge clk); cmd_stop = 1'b1; cmd_start = 1'b1;
    @(negedge clk); cmd_stop = 1'b0; cmd_start = 1'b0;
    idle(2);
    check(!active, "R9 stop wins over start", active, 0);
  endtask

  task automatic t_stop_abort;
    logic [31:0] w;
    wr_word(20, {16'd16, 8'h00, 8'h01});
    ack_en = 1'b0;
    pulse_start;
    idle(4);
    check(dm_req, "R4 request open", dm_req, 1);
    pulse_stop;
    idle(20);
    check(active && dm_req, "R8 stop waits on open request", {active, dm_req}, 2'b11);
    idle(STOP_LIMIT);
    check(!active && !dm_req, "R8 forced stop within limit", {active, dm_req}, 0);
    rd_word(20, w); check(w[0] == 1'b1, "R8 aborted descriptor still owned", w[0], 1);
  endtask

  task automatic t_stop_complete;
    logic [31:0] w;
    ack_en = 1'b1; ack_delay = 6; wait_cnt = 0;
    pulse_start;
    idle(2);
    check(dm_req, "R4 request held while waiting", dm_req, 1);
    pulse_stop;
    idle(15);
    check(!active && req_cnt == 4, "R8 late ack completes then stops", {active, req_cnt}, 4);
    rd_word(20, w); check(w[0] == 1'b0 && w[31:16] == 16'd16, "R8 writeback before stop", w, 32'h0010_0000);
    check(cur_ptr == 36'h60 && done_cnt == 4, "R5 no pulse without completion bit", done_cnt, 4);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_chain;
    t_start_ignored;
    t_resume_unowned;
    t_bypass;
    t_zero_len;
    t_stop_idle;
    t_stop_abort;
    t_stop_complete;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule